// File: doc/BRIEF.md
# Static Memory Chip-Select Controller

This block sits between a simple request/ready host bus and an external static memory bus made of up to eight banks. Address bits 30:28 of each host request pick one bank. The block then runs a fixed access sequence: a setup cycle, a strobe phase and a hold cycle. During that sequence it drives the bank's chip select, a read or write strobe, active-low byte-lane enables and write data placed on the correct lanes.

Each bank has its own settings: a wait count, a byte-ordering choice, and a switch that lets an external ready pin stretch the strobe. The two highest banks also have a programmable chip-select level. The host holds its request until it sees a one-cycle ready pulse. Read data, shifted down to bit 0 and zero-extended, is valid in that same cycle.

Top module: `smc_chipsel`

## Requirements
- R1: Address bits 30:28 select the bank, and no other address bit affects the choice. While an access is in progress exactly that bank's chip select is active. When no access is in progress every chip select is inactive.
- R2: Chip selects 0 to 5 are active low. Chip selects 6 and 7 are active high when their `cfg_cs_high` bit is 1 (bit 0 for bank 6, bit 1 for bank 7) and active low when it is 0.
- R3: Every access has three parts. First comes exactly one setup cycle, with the chip select active and both strobes high. Next comes the strobe phase. Last comes exactly one hold cycle, with the chip select active and both strobes high. The memory address stays stable for the whole access.
- R4: When the bank does not use external ready, the strobe phase lasts min(W,16)+1 cycles, where W is the bank's 5-bit `cfg_wait` field.
- R5: When the bank uses external ready, the strobe lasts at least min(W,16)+1 cycles. After that it continues until `mem_ready` is sampled high at the rising edge that closes a strobe cycle.
- R6: For a bank whose ready-use bit is 0, `mem_ready` has no effect on strobe length.
- R7: `req_ready` is high for exactly one cycle, namely the cycle after the hold cycle. It is never high in two consecutive cycles.
- R8: `req_size` encodes 0 as byte, 1 as half-word, and 2 or 3 as word. A half-word ignores address bit 0. In little-endian banks the byte at offset k uses lane k, a half-word at address bit 1 = h uses lanes 2h and 2h+1, and a word uses all four lanes. Lane n is data bits 8n+7:8n, and its enable is `mem_be_n[n]`, active low.
- R9: In a big-endian bank (`cfg_big_endian` bit = 1) the lanes are mirrored. A byte at offset k uses lane 3-k. A half-word at h uses lanes 2-2h and 3-2h. A word is unchanged.
- R10: Write data is taken from the low bits of `req_wdata` and shifted up to the lowest enabled lane. Read data is taken from the lowest enabled lane at the last strobe cycle, shifted down to bit 0 and zero-extended.
- R11: The output enable is asserted only during the strobe phase of reads, and the write enable only during the strobe phase of writes. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, right-justified, valid with `req_ready` |
| cfg_wait | input | 40 | Per-bank wait count, 5 bits per bank |
| cfg_big_endian | input | 8 | Per-bank big-endian lane mirroring |
| cfg_use_ready | input | 8 | Per-bank external ready enable |
| cfg_cs_high | input | 2 | Active-high chip select for banks 6 and 7 |
| mem_addr | output | 32 | Memory address |
| mem_cs | output | 8 | Chip selects, level per R2 |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 4 | Byte-lane enables, active low |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | External ready strobe |

## Verification
The assertions assume two things about the inputs. First, the configuration inputs, and `cfg_cs_high` in particular, stay constant during an access, because the checker recovers which chip select is active from the pin level and that polarity. Second, the host keeps `req_valid` and its request fields steady until the ready pulse and then drops `req_valid` before the next edge. The bench changes configuration only between accesses, and it lowers `req_valid` at the falling edge on which it sees `req_ready`. It drives `mem_ready` only at falling edges inside the strobe phase, so each ready sample is unambiguous.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_DONE
   } smc_state_t;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   // Lowest lane used by an access of the given size at the given offset.
   function automatic logic [1:0] base_lane(input logic [1:0] size,
                                            input logic [1:0] off,
                                            input logic       big);
      logic [1:0] lane;
      if (size == SZ_BYTE)      lane = big ? ~off : off;
      else if (size == SZ_HALF) lane = {big ? ~off[1] : off[1], 1'b0};
      else                      lane = 2'd0;
      return lane;
   endfunction

   // Bit mask of the enabled lanes, before shifting to the base lane.
   function automatic logic [3:0] size_lanes(input logic [1:0] size);
      logic [3:0] m;
      if (size == SZ_BYTE)      m = 4'b0001;
      else if (size == SZ_HALF) m = 4'b0011;
      else                      m = 4'b1111;
      return m;
   endfunction

endpackage

// File: rtl/smc_bank_decode.sv
module smc_bank_decode #(
   parameter int ADDR_W    = 32,
   parameter int NUM_BANKS = 8,
   parameter int SEL_LSB   = 28,
   parameter int WAIT_W    = 5,
   parameter int MAX_WAIT  = 16,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait,
   input  logic [NUM_BANKS-1:0]        cfg_big_endian,
   input  logic [NUM_BANKS-1:0]        cfg_use_ready,
   output logic [BANK_W-1:0]           bank,
   output logic [WAIT_W-1:0]           wait_eff,
   output logic                        big,
   output logic                        use_rdy
);

   localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);

   initial begin : p_param_check
      if (SEL_LSB + BANK_W > ADDR_W)
         $fatal(1, "bank select field exceeds address width");
      if (MAX_WAIT >= (1 << WAIT_W))
         $fatal(1, "wait cap does not fit the wait field");
   end

   logic [WAIT_W-1:0] wait_raw;

   always_comb begin
      bank     = addr[SEL_LSB +: BANK_W];
      wait_raw = cfg_wait[bank*WAIT_W +: WAIT_W];
      wait_eff = (wait_raw > WAIT_CAP) ? WAIT_CAP : wait_raw;
      big      = cfg_big_endian[bank];
      use_rdy  = cfg_use_ready[bank];
   end

endmodule

// File: rtl/smc_lane_map.sv
module smc_lane_map
   import smc_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic [1:0]        size,
   input  logic [1:0]        off,
   input  logic              big,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [LANES-1:0]  lane_en,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   initial begin : p_param_check
      if (DATA_W != 32) $fatal(1, "lane map supports a 32-bit data bus only");
   end

   logic [1:0]        base;
   logic [LANES-1:0]  raw_lanes;
   logic [DATA_W-1:0] size_mask;
   logic [4:0]        shamt;

   always_comb begin
      base      = base_lane(size, off, big);
      raw_lanes = size_lanes(size);
      shamt     = {base, 3'b000};
      lane_en   = raw_lanes << base;
   end

   // Expand the lane mask into a bit mask.
   for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign size_mask[g*8 +: 8] = {8{raw_lanes[g]}};
   end

   always_comb begin
      mem_wdata  = (host_wdata & size_mask) << shamt;
      host_rdata = (mem_rdata >> shamt) & size_mask;
   end

endmodule

// File: rtl/smc_cycle_fsm.sv
module smc_cycle_fsm
   import smc_pkg::*;
#(
   parameter int WAIT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  logic              use_rdy,
   input  logic              mem_ready,
   output logic              idle,
   output logic              cs_on,
   output logic              oe_on,
   output logic              we_on,
   output logic              capture,
   output logic              done
);

   smc_state_t        state;
   logic [WAIT_W-1:0] cnt;
   logic              strobe_end;

   always_comb begin
      strobe_end = (state == ST_STROBE) && (cnt == '0) && (!use_rdy || mem_ready);
      idle       = (state == ST_IDLE);
      cs_on      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
      oe_on      = (state == ST_STROBE) && !is_write;
      we_on      = (state == ST_STROBE) && is_write;
      capture    = strobe_end;
      done       = (state == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE:   if (start) state <= ST_SETUP;
            ST_SETUP: begin
               cnt   <= wait_cnt;
               state <= ST_STROBE;
            end
            ST_STROBE: begin
               if (strobe_end)      state <= ST_HOLD;
               else if (cnt != '0)  cnt   <= cnt - 1'b1;
            end
            ST_HOLD:   state <= ST_DONE;
            ST_DONE:   state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/smc_chipsel.sv
module smc_chipsel
   import smc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 8,
   parameter int SEL_LSB   = 28,
   parameter int WAIT_W    = 5,
   parameter int MAX_WAIT  = 16,
   parameter int POL_BANKS = 2,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int LANES    = DATA_W / 8,
   localparam int POL_BASE = NUM_BANKS - POL_BANKS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [1:0]                  req_size,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic                        req_ready,
   output logic [DATA_W-1:0]           req_rdata,
   input  logic [NUM_BANKS*WAIT_W-1:0] cfg_wait,
   input  logic [NUM_BANKS-1:0]        cfg_big_endian,
   input  logic [NUM_BANKS-1:0]        cfg_use_ready,
   input  logic [POL_BANKS-1:0]        cfg_cs_high,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [NUM_BANKS-1:0]        mem_cs,
   output logic                        mem_oe_n,
   output logic                        mem_we_n,
   output logic [LANES-1:0]            mem_be_n,
   output logic [DATA_W-1:0]           mem_wdata,
   input  logic [DATA_W-1:0]           mem_rdata,
   input  logic                        mem_ready
);

   initial begin : p_param_check
      if (POL_BANKS < 1 || POL_BANKS > NUM_BANKS)
         $fatal(1, "programmable-polarity bank count out of range");
      if (NUM_BANKS != (1 << BANK_W))
         $fatal(1, "bank count must be a power of two");
   end

   // Decode of the incoming request
   logic [BANK_W-1:0] dec_bank;
   logic [WAIT_W-1:0] dec_wait;
   logic              dec_big;
   logic              dec_rdy;

   smc_bank_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .SEL_LSB   (SEL_LSB),
      .WAIT_W    (WAIT_W),
      .MAX_WAIT  (MAX_WAIT)
   ) u_decode (
      .addr           (req_addr),
      .cfg_wait       (cfg_wait),
      .cfg_big_endian (cfg_big_endian),
      .cfg_use_ready  (cfg_use_ready),
      .bank           (dec_bank),
      .wait_eff       (dec_wait),
      .big            (dec_big),
      .use_rdy        (dec_rdy)
   );

   // Request held for the whole access
   logic              idle;
   logic              accept;
   logic [ADDR_W-1:0] a_addr;
   logic [DATA_W-1:0] a_wdata;
   logic [1:0]        a_size;
   logic              a_wr;
   logic [BANK_W-1:0] a_bank;
   logic [WAIT_W-1:0] a_wait;
   logic              a_big;
   logic              a_rdy;

   assign accept = idle && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_addr  <= '0;
         a_wdata <= '0;
         a_size  <= '0;
         a_wr    <= 1'b0;
         a_bank  <= '0;
         a_wait  <= '0;
         a_big   <= 1'b0;
         a_rdy   <= 1'b0;
      end else if (accept) begin
         a_addr  <= req_addr;
         a_wdata <= req_wdata;
         a_size  <= req_size;
         a_wr    <= req_write;
         a_bank  <= dec_bank;
         a_wait  <= dec_wait;
         a_big   <= dec_big;
         a_rdy   <= dec_rdy;
      end
   end

   // Cycle sequencing
   logic cs_on, oe_on, we_on, capture, done;

   smc_cycle_fsm #(
      .WAIT_W (WAIT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .is_write  (a_wr),
      .wait_cnt  (a_wait),
      .use_rdy   (a_rdy),
      .mem_ready (mem_ready),
      .idle      (idle),
      .cs_on     (cs_on),
      .oe_on     (oe_on),
      .we_on     (we_on),
      .capture   (capture),
      .done      (done)
   );

   // Byte lanes and data steering
   logic [LANES-1:0]  lane_en;
   logic [DATA_W-1:0] lane_rdata;

   smc_lane_map #(
      .DATA_W (DATA_W)
   ) u_lanes (
      .size       (a_size),
      .off        (a_addr[1:0]),
      .big        (a_big),
      .host_wdata (a_wdata),
      .mem_rdata  (mem_rdata),
      .lane_en    (lane_en),
      .mem_wdata  (mem_wdata),
      .host_rdata (lane_rdata)
   );

   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (capture && !a_wr) rdata_q <= lane_rdata;
   end

   // Chip select generation with per-bank polarity
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      logic sel;
      assign sel = cs_on && (a_bank == BANK_W'(b));
      if (b >= POL_BASE) begin : g_prog
         assign mem_cs[b] = cfg_cs_high[b-POL_BASE] ? sel : ~sel;
      end else begin : g_low
         assign mem_cs[b] = ~sel;
      end
   end

   assign mem_addr  = a_addr;
   assign mem_oe_n  = ~oe_on;
   assign mem_we_n  = ~we_on;
   assign mem_be_n  = cs_on ? ~lane_en : '1;
   assign req_ready = done;
   assign req_rdata = rdata_q;

endmodule

// File: rtl/smc_chipsel_chk.sv
module smc_chipsel_chk #(
   parameter int ADDR_W    = 32,
   parameter int NUM_BANKS = 8,
   parameter int POL_BANKS = 2,
   parameter int LANES     = 4,
   localparam int POL_BASE = NUM_BANKS - POL_BANKS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_ready,
   input logic [POL_BANKS-1:0] cfg_cs_high,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic [NUM_BANKS-1:0] mem_cs,
   input logic                 mem_oe_n,
   input logic                 mem_we_n,
   input logic [LANES-1:0]     mem_be_n
);

   logic [NUM_BANKS-1:0] off_level;
   logic [NUM_BANKS-1:0] act;
   logic                 any_cs;
   logic                 quiet;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lvl
      if (b >= POL_BASE) begin : g_prog
         assign off_level[b] = ~cfg_cs_high[b-POL_BASE];
      end else begin : g_low
         assign off_level[b] = 1'b1;
      end
   end

   assign act    = mem_cs ^ off_level;
   assign any_cs = (act != '0);
   assign quiet  = mem_oe_n && mem_we_n;

   assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act));

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !quiet |-> any_cs);

   assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!quiet && $past(quiet)) |-> ($past(act) == act));

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cs && $past(any_cs)) |-> $stable(mem_addr));

   assert_ready_after_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ($past(act) != '0) && $past(quiet));

   assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   assert_write_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_be_n != '1));

endmodule

bind smc_chipsel smc_chipsel_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS),
   .POL_BANKS (POL_BANKS),
   .LANES     (LANES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .cfg_cs_high (cfg_cs_high),
   .mem_addr    (mem_addr),
   .mem_cs      (mem_cs),
   .mem_oe_n    (mem_oe_n),
   .mem_we_n    (mem_we_n),
   .mem_be_n    (mem_be_n)
);

// File: tb/smc_chipsel_tb.sv
module smc_chipsel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic [39:0] cfg_wait = '0;
   logic [7:0]  cfg_big_endian = '0;
   logic [7:0]  cfg_use_ready = '0;
   logic [1:0]  cfg_cs_high = '0;
   logic [31:0] mem_addr;
   logic [7:0]  mem_cs;
   logic        mem_oe_n;
   logic        mem_we_n;
   logic [3:0]  mem_be_n;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 32'hA1B2C3D4;
   logic        mem_ready = 1'b1;

   int total = 0;
   int bad = 0;

   // Results of the most recent access
   int          o_setup, o_strobe, o_hold;
   logic [7:0]  o_cs;
   logic [3:0]  o_be_n;
   logic [31:0] o_wdata;
   logic [31:0] o_rdata;
   logic        o_oe, o_we;

   always #4 clk = ~clk;

   smc_chipsel u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_size       (req_size),
      .req_addr       (req_addr),
      .req_wdata      (req_wdata),
      .req_ready      (req_ready),
      .req_rdata      (req_rdata),
      .cfg_wait       (cfg_wait),
      .cfg_big_endian (cfg_big_endian),
      .cfg_use_ready  (cfg_use_ready),
      .cfg_cs_high    (cfg_cs_high),
      .mem_addr       (mem_addr),
      .mem_cs         (mem_cs),
      .mem_oe_n       (mem_oe_n),
      .mem_we_n       (mem_we_n),
      .mem_be_n       (mem_be_n),
      .mem_wdata      (mem_wdata),
      .mem_rdata      (mem_rdata),
      .mem_ready      (mem_ready)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] idle_cs();
      return {~cfg_cs_high[1], ~cfg_cs_high[0], 6'b111111};
   endfunction

   function automatic int exp_base(input logic [1:0] sz, input logic [1:0] off, input bit big);
      if (sz == 2'd0) return big ? 3 - int'(off) : int'(off);
      if (sz == 2'd1) return big ? (off[1] ? 0 : 2) : (off[1] ? 2 : 0);
      return 0;
   endfunction

   function automatic logic [31:0] exp_smask(input logic [1:0] sz);
      if (sz == 2'd0) return 32'h0000_00FF;
      if (sz == 2'd1) return 32'h0000_FFFF;
      return 32'hFFFF_FFFF;
   endfunction

   function automatic void set_wait(input int bank, input logic [4:0] w);
      cfg_wait[bank*5 +: 5] = w;
   endfunction

   // Runs one host access and records what the memory side showed.
   // rdy_at: 0 keeps mem_ready high; otherwise mem_ready rises at the
   // falling edge of strobe cycle rdy_at.
   task automatic do_access(input logic [31:0] addr, input logic [1:0] sz,
                            input bit wr, input logic [31:0] wd, input int rdy_at);
      int guard;
      @(negedge clk);
      req_addr  = addr;
      req_size  = sz;
      req_write = wr;
      req_wdata = wd;
      req_valid = 1'b1;
      mem_ready = (rdy_at == 0);
      o_setup = 0; o_strobe = 0; o_hold = 0;
      o_cs = '1; o_be_n = '1; o_wdata = '0; o_rdata = '0; o_oe = 0; o_we = 0;
      guard = 0;
      while (guard < 2000) begin
         @(negedge clk);
         guard++;
         if (req_ready) begin
            o_rdata = req_rdata;
            break;
         end
         if (!mem_oe_n || !mem_we_n) begin
            o_strobe++;
            o_be_n  = mem_be_n;
            o_wdata = mem_wdata;
            o_oe    = o_oe | !mem_oe_n;
            o_we    = o_we | !mem_we_n;
            if (rdy_at != 0 && o_strobe >= rdy_at) mem_ready = 1'b1;
         end else if (mem_cs != idle_cs()) begin
            if (o_strobe == 0) begin
               o_setup++;
               o_cs = mem_cs;
            end else begin
               o_hold++;
            end
         end
      end
      req_valid = 1'b0;
      mem_ready = 1'b1;
      chk(guard < 2000, "R7 access completes", guard, 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 ready is a single pulse", req_ready, 0);
   endtask

   task automatic test_reset();
      chk(mem_cs == 8'b1111_1111, "R1 idle chip selects after reset", mem_cs, 8'hFF);
      chk(mem_oe_n && mem_we_n, "R11 strobes idle after reset", {mem_oe_n, mem_we_n}, 2'b11);
      chk(mem_be_n == 4'hF, "R8 lanes idle after reset", mem_be_n, 4'hF);
      chk(req_ready == 1'b0, "R7 no ready after reset", req_ready, 0);
   endtask

   task automatic test_decode_polarity();
      cfg_cs_high = 2'b10;
      for (int b = 0; b < 8; b++) begin
         logic [31:0] a;
         a = {(b % 2 == 1), 3'(b), 28'h0123458};
         do_access(a, 2'd2, 1'b0, '0, 0);
         chk(o_cs == (idle_cs() ^ (8'd1 << b)), $sformatf("R1 R2 bank %0d select", b), o_cs, idle_cs() ^ (8'd1 << b));
      end
      cfg_cs_high = 2'b01;
      for (int b = 6; b < 8; b++) begin
         do_access({1'b0, 3'(b), 28'h0000010}, 2'd2, 1'b0, '0, 0);
         chk(o_cs == (idle_cs() ^ (8'd1 << b)), $sformatf("R2 swapped polarity bank %0d", b), o_cs, idle_cs() ^ (8'd1 << b));
      end
      @(negedge clk);
      chk(mem_cs == idle_cs(), "R2 idle level follows polarity", mem_cs, idle_cs());
      cfg_cs_high = 2'b00;
   endtask

   task automatic test_wait_lengths();
      int waits[4] = '{0, 3, 16, 31};
      foreach (waits[i]) begin
         int e;
         set_wait(2, 5'(waits[i]));
         e = (waits[i] > 16 ? 16 : waits[i]) + 1;
         do_access(32'h2000_0040, 2'd2, 1'b0, '0, 0);
         chk(o_strobe == e, $sformatf("R4 strobe length wait=%0d", waits[i]), o_strobe, e);
         chk(o_setup == 1 && o_hold == 1, "R3 one setup and one hold cycle", {o_setup[15:0], o_hold[15:0]}, 32'h0001_0001);
      end
   endtask

   task automatic test_ext_ready();
      set_wait(3, 5'd2);
      cfg_use_ready[3] = 1'b1;
      do_access(32'h3000_0000, 2'd2, 1'b0, '0, 7);
      chk(o_strobe == 7, "R5 ready stretches strobe", o_strobe, 7);
      do_access(32'h3000_0000, 2'd2, 1'b0, '0, 2);
      chk(o_strobe == 3, "R5 early ready keeps wait count", o_strobe, 3);
      do_access(32'h3000_0000, 2'd2, 1'b1, 32'h1234_5678, 10);
      chk(o_strobe == 10, "R5 ready stretches write strobe", o_strobe, 10);
   endtask

   task automatic test_ready_ignored();
      set_wait(4, 5'd1);
      cfg_use_ready[4] = 1'b0;
      do_access(32'h4000_0000, 2'd2, 1'b0, '0, 1000);
      chk(o_strobe == 2, "R6 ready ignored when unused", o_strobe, 2);
   endtask

   task automatic lane_write(input int bank, input logic [1:0] sz, input logic [1:0] off, input bit big);
      logic [31:0] wd, exp_w, bmask;
      logic [3:0]  exp_be;
      int          base;
      wd     = 32'hC5D6E7F8 ^ {30'd0, off};
      base   = exp_base(sz, off, big);
      exp_w  = (wd & exp_smask(sz)) << (8 * base);
      bmask  = exp_smask(sz) << (8 * base);
      exp_be = ~(((sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111) << base);
      do_access({1'b0, 3'(bank), 26'h0000100, off}, sz, 1'b1, wd, 0);
      chk(o_be_n == exp_be, $sformatf("%s lanes size=%0d off=%0d", big ? "R9" : "R8", sz, off), o_be_n, exp_be);
      chk((o_wdata & bmask) == exp_w, $sformatf("R10 write placement size=%0d off=%0d", sz, off), o_wdata & bmask, exp_w);
      chk(o_we && !o_oe, "R11 write uses write enable", {o_we, o_oe}, 2'b10);
   endtask

   task automatic test_lanes_le();
      cfg_big_endian[1] = 1'b0;
      for (int k = 0; k < 4; k++) lane_write(1, 2'd0, 2'(k), 1'b0);
      lane_write(1, 2'd1, 2'd0, 1'b0);
      lane_write(1, 2'd1, 2'd3, 1'b0);
      lane_write(1, 2'd2, 2'd0, 1'b0);
      lane_write(1, 2'd3, 2'd0, 1'b0);
   endtask

   task automatic test_lanes_be();
      cfg_big_endian[5] = 1'b1;
      for (int k = 0; k < 4; k++) lane_write(5, 2'd0, 2'(k), 1'b1);
      lane_write(5, 2'd1, 2'd0, 1'b1);
      lane_write(5, 2'd1, 2'd2, 1'b1);
      lane_write(5, 2'd2, 2'd0, 1'b1);
   endtask

   task automatic read_one(input int bank, input logic [1:0] sz, input logic [1:0] off,
                           input bit big, input logic [31:0] exp);
      do_access({1'b0, 3'(bank), 26'h0000200, off}, sz, 1'b0, '0, 0);
      chk(o_rdata == exp, $sformatf("R10 read size=%0d off=%0d big=%0d", sz, off, big), o_rdata, exp);
      chk(o_oe && !o_we, "R11 read uses output enable", {o_oe, o_we}, 2'b10);
   endtask

   task automatic test_read_extract();
      mem_rdata = 32'hA1B2C3D4;
      cfg_big_endian[1] = 1'b0;
      cfg_big_endian[5] = 1'b1;
      read_one(1, 2'd0, 2'd1, 1'b0, 32'h0000_00C3);
      read_one(5, 2'd0, 2'd1, 1'b1, 32'h0000_00B2);
      read_one(5, 2'd0, 2'd3, 1'b1, 32'h0000_00D4);
      read_one(1, 2'd1, 2'd2, 1'b0, 32'h0000_A1B2);
      read_one(5, 2'd1, 2'd0, 1'b1, 32'h0000_A1B2);
      read_one(5, 2'd1, 2'd2, 1'b1, 32'h0000_C3D4);
      read_one(1, 2'd2, 2'd0, 1'b0, 32'hA1B2_C3D4);
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_decode_polarity();
      test_wait_lengths();
      test_ext_ready();
      test_ready_ignored();
      test_lanes_le();
      test_lanes_be();
      test_read_extract();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule